// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplex Mode

This block is a small storage register of eight bits. A three-bit index picks one bit, and a single data line supplies the value for it. The block has two active-low controls, a clear and an enable. Together they choose one of four behaviours. In write mode only the indexed bit is replaced. In hold mode the register is frozen. In demultiplex mode the indexed output carries the data bit and every other output is forced low. In clear mode the whole register is forced low at once.

The state is held in flip-flops on a system clock, so the write and demultiplex modes act at the rising edge. They use the index and data present at that edge. Clear mode does not wait for the clock and empties the register immediately. The outputs are the state flip-flops themselves. A user who wants a wider word places several of these side by side and steers them through their enables.

Top module: `addr_latch`

## Requirements
- R1: With clear high and enable low (write mode), at the rising clock edge the bit whose index equals `addr` takes the value of `din`.
- R2: In write mode, every bit other than the indexed one keeps its value across the edge.
- R3: With clear high and enable high (hold mode), `q` does not change at the clock edge, whatever `addr` and `din` do.
- R4: With clear low and enable low (demultiplex mode), after the clock edge `q` equals `din` shifted left by `addr`. At most one bit is set. That pattern stays in place when the block then moves to hold mode.
- R5: With clear low and enable high (clear mode), `q` becomes all zero at once, in the middle of a clock period. It stays zero at the following edges, whatever `addr` and `din` do.
- R6: `addr` is a plain binary index with `addr[2]` as its most significant bit: value 0 selects `q[0]` and value 7 selects `q[7]`.
- R7: Apart from clear mode, `q` changes only at a rising clock edge. A change of the inputs between edges leaves `q` as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; write and demultiplex act on its rising edge |
| clr_n | input | 1 | Active-low clear; with `en_n` it selects the mode |
| en_n | input | 1 | Active-low enable; with `clr_n` it selects the mode |
| addr | input | ADDR_W (3) | Binary index of the bit to write or route to |
| din | input | 1 | Data bit to be stored or routed |
| q | output | 2**ADDR_W (8) | Parallel outputs, taken straight from the state bits |

## Verification
The hardest case to reach from the ports is a clear that strikes in the middle of a clock period, when the next edge is not involved. The stimulus waits a little past a rising edge, moves the controls into clear mode well before the falling edge and samples `q` at once. The clear is then held through the next edge, so that an edge cannot hide a late clear. Random runs of all four modes also cover demultiplex mode running straight into hold or write with no clear between them, where the register must keep the one-hot pattern it last routed.

// File: rtl/addr_latch_pkg.sv
`timescale 1ns/1ps
package addr_latch_pkg;

  // Behaviour chosen by the two active-low controls, encoded as {clr_n, en_n}.
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_HOLD  = 2'b11
  } latch_mode_e;

  function automatic latch_mode_e decode_mode(input logic clr_n, input logic en_n);
    latch_mode_e m;
    case ({clr_n, en_n})
      2'b00:   m = MODE_DEMUX;
      2'b01:   m = MODE_CLEAR;
      2'b10:   m = MODE_WRITE;
      default: m = MODE_HOLD;
    endcase
    return m;
  endfunction

  // True for the modes that load new content at the clock edge.
  function automatic logic mode_loads(input latch_mode_e m);
    return (m == MODE_WRITE) || (m == MODE_DEMUX);
  endfunction

endpackage

// File: rtl/al_mode_dec.sv
`timescale 1ns/1ps
module al_mode_dec
  import addr_latch_pkg::*;
(
  input  logic        clr_n,
  input  logic        en_n,
  output latch_mode_e mode,
  output logic        wipe,
  output logic        load_any,
  output logic        route
);
  always_comb begin
    mode     = decode_mode(clr_n, en_n);
    wipe     = (mode == MODE_CLEAR);
    load_any = mode_loads(mode);
    route    = (mode == MODE_DEMUX);
  end
endmodule

// File: rtl/al_index_dec.sv
`timescale 1ns/1ps
module al_index_dec #(
  parameter int ADDR_W = 3,
  localparam int WIDTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WIDTH-1:0]  hit
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/al_bit_cell.sv
`timescale 1ns/1ps
module al_bit_cell (
  input  logic clk,
  input  logic wipe,
  input  logic load,
  input  logic zero,
  input  logic d,
  output logic q
);
  // The clear is asynchronous; loading beats zeroing, and zeroing beats holding.
  always_ff @(posedge clk or posedge wipe) begin
    if (wipe)      q <= 1'b0;
    else if (load) q <= d;
    else if (zero) q <= 1'b0;
  end
endmodule

// File: rtl/addr_latch.sv
`timescale 1ns/1ps
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int WIDTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [WIDTH-1:0]  q
);
  latch_mode_e      mode;
  logic             wipe;
  logic             load_any;
  logic             route;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] wr_vec;
  logic [WIDTH-1:0] zero_vec;

  al_mode_dec u_mode (
    .clr_n    (clr_n),
    .en_n     (en_n),
    .mode     (mode),
    .wipe     (wipe),
    .load_any (load_any),
    .route    (route)
  );

  al_index_dec #(.ADDR_W(ADDR_W)) u_index (
    .addr (addr),
    .hit  (hit)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign wr_vec[i]   = load_any & hit[i];
    assign zero_vec[i] = route & ~hit[i];

    al_bit_cell u_cell (
      .clk  (clk),
      .wipe (wipe),
      .load (wr_vec[i]),
      .zero (zero_vec[i]),
      .d    (din),
      .q    (q[i])
    );
  end
endmodule

// File: rtl/addr_latch_chk.sv
`timescale 1ns/1ps
module addr_latch_chk #(
  parameter int ADDR_W = 3,
  localparam int WIDTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              clr_n,
  input logic              en_n,
  input logic [ADDR_W-1:0] addr,
  input logic              din,
  input logic [WIDTH-1:0]  q,
  input logic              wipe,
  input logic [WIDTH-1:0]  wr_vec
);
  // Set when a clear struck between two edges, so that checks comparing with
  // the previous edge excuse that period.
  logic dirty;
  always_ff @(posedge clk or posedge wipe) begin
    if (wipe) dirty <= 1'b1;
    else      dirty <= 1'b0;
  end

  a_r1_write_addressed: assert property (@(posedge clk) disable iff (wipe)
    (clr_n && !en_n) |=> (dirty || q[$past(addr)] == $past(din)));

  a_r2_write_others: assert property (@(posedge clk) disable iff (wipe)
    (clr_n && !en_n) |=>
      (dirty || ((q ^ $past(q)) & ~(WIDTH'(1) << $past(addr))) == '0));

  a_r3_hold_frozen: assert property (@(posedge clk) disable iff (wipe)
    (clr_n && en_n) |=> (dirty || $stable(q)));

  a_r4_demux_pattern: assert property (@(posedge clk) disable iff (wipe)
    (!clr_n && !en_n) |=> (dirty || q == (WIDTH'($past(din)) << $past(addr))));

  a_r4_demux_onehot: assert property (@(posedge clk) disable iff (wipe)
    (!clr_n && !en_n) |=> $onehot0(q));

  a_r5_clear_zero: assert property (@(posedge clk)
    (!clr_n && en_n) |-> (q == '0));

  a_r6_single_target: assert property (@(posedge clk) disable iff (wipe)
    $onehot0(wr_vec));
endmodule

bind addr_latch addr_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .en_n   (en_n),
  .addr   (addr),
  .din    (din),
  .q      (q),
  .wipe   (wipe),
  .wr_vec (wr_vec)
);

// File: tb/test_addr_latch.sv
`timescale 1ns/1ps
module test_addr_latch;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       en_n = 1'b1;
  logic [2:0] addr = 3'd0;
  logic       din = 1'b0;
  logic [7:0] q;

  always #2.5 clk = ~clk;

  addr_latch i_addr_latch (
    .clk   (clk),
    .clr_n (clr_n),
    .en_n  (en_n),
    .addr  (addr),
    .din   (din),
    .q     (q)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  logic [7:0] model = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%02h expected %02h", tag, act, exp);
    end
  endtask

  // Reference for the four-mode table, written as a priority chain.
  function automatic logic [7:0] ref_next(input logic [7:0] s, input logic c,
                                          input logic e, input logic [2:0] a,
                                          input logic d);
    logic [7:0] r;
    if (c && e)      r = s;
    else if (c)      begin r = s;     r[a] = d; end
    else if (!e)     begin r = 8'h00; r[a] = d; end
    else             r = 8'h00;
    return r;
  endfunction

  // Driver: sets inputs at the falling edge, checks that nothing moved yet
  // (R7) or that the clear already acted (R5), then queues the post-edge value.
  task automatic apply(input logic c, input logic e, input logic [2:0] a,
                       input logic d, input string tag);
    @(negedge clk);
    clr_n = c; en_n = e; addr = a; din = d;
    #0.5;
    if (!c && e) begin
      model = 8'h00;
      check(q, 8'h00, "R5 immediate clear");
    end else begin
      check(q, model, "R7 no change before edge");
    end
    model = ref_next(model, c, e, a, d);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // R5: clear raised shortly after an edge, sampled before the next one.
  task automatic mid_clear();
    @(posedge clk);
    #1.5;
    clr_n = 1'b0; en_n = 1'b1;
    addr = 3'($urandom); din = 1'($urandom);
    #0.5;
    check(q, 8'h00, "R5 mid-cycle clear");
    model = 8'h00;
    apply(1'b0, 1'b1, 3'($urandom), 1'($urandom), "R5 clear held");
  endtask

  // Monitor: compares one queued item after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(q, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL R7 watchdog: q=%02h expected run to complete", q);
    finish_run();
  end

  initial begin
    logic [7:0] pat;
    #1;
    check(q, 8'h00, "R5 reset state");
    apply(1'b0, 1'b1, 3'd5, 1'b1, "R5 clear ignores inputs");
    apply(1'b0, 1'b1, 3'd2, 1'b0, "R5 clear ignores inputs");

    // R1 R6: walk the index and write a pattern bit by bit.
    pat = 8'hA5;
    for (int i = 0; i < 8; i++) apply(1'b1, 1'b0, 3'(i), pat[i], "R1 R6 write walk");
    // R6: a lone set bit at index 6 from an all-zero register.
    apply(1'b0, 1'b1, 3'd0, 1'b0, "R5 clear");
    apply(1'b1, 1'b0, 3'd6, 1'b1, "R6 index 6 sets q[6]");
    apply(1'b1, 1'b0, 3'd0, 1'b1, "R6 index 0 sets q[0]");
    apply(1'b1, 1'b0, 3'd7, 1'b1, "R6 index 7 sets q[7]");
    // R2: overwrite one bit, the others must stay.
    apply(1'b1, 1'b0, 3'd6, 1'b0, "R2 single overwrite");
    apply(1'b1, 1'b0, 3'd3, 1'b1, "R2 single overwrite");

    // R3: hold while the index and data wander.
    for (int i = 0; i < 6; i++)
      apply(1'b1, 1'b1, 3'($urandom), 1'($urandom), "R3 hold ignores inputs");

    // R4: route both data values to every index.
    for (int i = 0; i < 8; i++) begin
      apply(1'b0, 1'b0, 3'(i), 1'b1, "R4 demux one");
      apply(1'b0, 1'b0, 3'(i), 1'b0, "R4 demux zero");
    end
    apply(1'b0, 1'b0, 3'd4, 1'b1, "R4 demux one");
    apply(1'b1, 1'b1, 3'd1, 1'b1, "R4 pattern kept in hold");
    apply(1'b1, 1'b1, 3'd7, 1'b0, "R4 pattern kept in hold");

    // R5: clear in the middle of a period after a write.
    apply(1'b1, 1'b0, 3'd2, 1'b1, "R1 write before clear");
    mid_clear();

    // Random mix of all four modes.
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 19) == 0) mid_clear();
      else apply(1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
                 "R1 R2 R3 R4 R5 random mode mix");
    end

    @(posedge clk);
    #2;
    finish_run();
  end
endmodule